// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the steering logic of a single-cycle RV32I core. It takes three fields of the current instruction word: the opcode, the 3-bit minor function code and the 7-bit major function code. From these it drives every select and enable of the datapath in the same cycle. It has no state and no clock. The instruction fetched this cycle is fully decoded before the register file write edge that ends the cycle.

The decode runs in two steps. First the opcode is reduced to an instruction class. That class sets the enables and the write-back source, and a separate unit derives the ALU operation from the class and the function fields. The write-back source chooses one of four paths:

- the ALU result
- data returned by memory
- the link address (PC+4)
- the upper immediate

Opcodes outside the supported set leave every state-changing enable low. Fence and system opcodes are among them.

Top module: `ctrl_decoder`

## Requirements
- R1: For opcode 0110011 (register-register), reg_write_o=1, alu_src_o=0 (second operand from rs2), mem_read_o=0, mem_write_o=0, branch_o=0, and wb_sel_o=0 (ALU result).
- R2: ALU operation codes on alu_op_o are ADD=0, SUB=1, AND=2, OR=3, XOR=4, SLT=5, SLTU=6, SLL=7, SRL=8, SRA=9. For register-register with funct7 bit 5 clear, funct3 selects the operation as follows: 000 ADD, 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL, 110 OR, 111 AND.
- R3: For register-register with funct7 bit 5 set, funct3=000 gives SUB and funct3=101 gives SRA. For every other funct3 value, funct7 bit 5 does not change alu_op_o.
- R4: For opcode 0010011 (register-immediate ALU), reg_write_o=1, alu_src_o=1 and wb_sel_o=0, with alu_op_o taken from the R2 table. funct3=000 always gives ADD whatever funct7 holds, and funct3=101 with funct7 bit 5 set gives SRA.
- R5: For opcode 0000011 (load), mem_read_o=1, reg_write_o=1, mem_write_o=0, alu_src_o=1, wb_sel_o=1 (memory data) and alu_op_o=ADD.
- R6: For opcode 0100011 (store), mem_write_o=1, mem_read_o=0, reg_write_o=0, alu_src_o=1 and alu_op_o=ADD.
- R7: For opcode 1100011 (conditional branch), branch_o=1, reg_write_o=0, alu_src_o=0, both memory enables are 0, and alu_op_o=SUB for every funct3 and funct7.
- R8: For opcode 1101111 (jump and link) and opcode 1100111 (jump and link register), reg_write_o=1, wb_sel_o=2 (PC+4), alu_src_o=1, alu_op_o=ADD, and branch_o and both memory enables are 0.
- R9: For opcode 0110111 (load upper immediate) and opcode 0010111 (add upper immediate to PC), reg_write_o=1, wb_sel_o=3 (upper immediate), alu_src_o=1, alu_op_o=ADD, and the memory enables and branch_o are 0.
- R10: For any other opcode, reg_write_o, mem_read_o, mem_write_o and branch_o are all 0, alu_src_o=0, alu_op_o=ADD and wb_sel_o=0.
- R11: mem_read_o and mem_write_o are never both 1, and reg_write_o is 0 whenever branch_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Opcode field, instruction bits 6..0 |
| funct3_i | input | 3 | Minor function field, instruction bits 14..12 |
| funct7_i | input | 7 | Major function field, instruction bits 31..25 |
| reg_write_o | output | 1 | Register file write enable |
| alu_src_o | output | 1 | 1 selects the immediate as second ALU operand, 0 selects rs2 |
| mem_read_o | output | 1 | Data memory read enable |
| mem_write_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch instruction |
| alu_op_o | output | 4 | ALU operation code (R2 encoding) |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4, 3 upper immediate |

## Verification
The enable decode and the ALU-operation derivation act on the same instruction in the same cycle. A fault appears when funct bits that matter for one class leak into another. The bench provokes this by presenting each class with function fields that would select SUB or SRA in a register-register instruction. It uses funct7 bit 5 set together with funct3 of 000 and 101. It then judges the full output word against the class's own expected operation. Examples are ADD for an immediate add with bit 5 set, SUB for every branch funct3, and ADD for loads, stores, jumps and upper-immediate forms.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int ALUOP_W = 4;
  localparam int WBSEL_W = 2;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_SLT  = 4'd5,
    ALU_SLTU = 4'd6,
    ALU_SLL  = 4'd7,
    ALU_SRL  = 4'd8,
    ALU_SRA  = 4'd9
  } alu_op_e;

  typedef enum logic [WBSEL_W-1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2,
    WB_UIMM = 2'd3
  } wb_sel_e;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_REG,
    CLS_IMM,
    CLS_LOAD,
    CLS_STORE,
    CLS_BRANCH,
    CLS_JAL,
    CLS_JALR,
    CLS_LUI,
    CLS_AUIPC
  } instr_class_e;

  typedef struct packed {
    logic    reg_write;
    logic    alu_src;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    wb_sel_e wb_sel;
  } ctrl_bits_t;

endpackage

// File: rtl/opcode_classifier.sv
module opcode_classifier
  import ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output instr_class_e     cls_o
);

  always_comb begin
    unique case (opcode_i)
      OPC_REG:    cls_o = CLS_REG;
      OPC_IMM:    cls_o = CLS_IMM;
      OPC_LOAD:   cls_o = CLS_LOAD;
      OPC_STORE:  cls_o = CLS_STORE;
      OPC_BRANCH: cls_o = CLS_BRANCH;
      OPC_JAL:    cls_o = CLS_JAL;
      OPC_JALR:   cls_o = CLS_JALR;
      OPC_LUI:    cls_o = CLS_LUI;
      OPC_AUIPC:  cls_o = CLS_AUIPC;
      default:    cls_o = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/main_ctrl.sv
module main_ctrl
  import ctrl_pkg::*;
(
  input  instr_class_e cls_i,
  output ctrl_bits_t   ctrl_o
);

  always_comb begin
    // safe default: nothing architectural changes
    ctrl_o = '{reg_write: 1'b0, alu_src: 1'b0, mem_read: 1'b0,
               mem_write: 1'b0, branch: 1'b0, wb_sel: WB_ALU};
    unique case (cls_i)
      CLS_REG: begin
        ctrl_o.reg_write = 1'b1;
      end
      CLS_IMM: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
      end
      CLS_LOAD: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.wb_sel    = WB_MEM;
      end
      CLS_STORE: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      CLS_BRANCH: begin
        ctrl_o.branch    = 1'b1;
      end
      CLS_JAL, CLS_JALR: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.wb_sel    = WB_LINK;
      end
      CLS_LUI, CLS_AUIPC: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.wb_sel    = WB_UIMM;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import ctrl_pkg::*;
#(
  parameter int ALT_BIT = 5   // funct7 bit that picks the alternate operation
) (
  input  instr_class_e    cls_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output alu_op_e         alu_op_o
);

  logic alt;
  assign alt = funct7_i[ALT_BIT];

  // shared funct3 table; sub_ok permits the alternate on funct3=000
  function automatic alu_op_e table_op(input logic [F3_W-1:0] f3,
                                       input logic alt_b,
                                       input logic sub_ok);
    alu_op_e r;
    unique case (f3)
      3'b000:  r = (alt_b && sub_ok) ? ALU_SUB : ALU_ADD;
      3'b001:  r = ALU_SLL;
      3'b010:  r = ALU_SLT;
      3'b011:  r = ALU_SLTU;
      3'b100:  r = ALU_XOR;
      3'b101:  r = alt_b ? ALU_SRA : ALU_SRL;
      3'b110:  r = ALU_OR;
      default: r = ALU_AND;
    endcase
    return r;
  endfunction

  always_comb begin
    unique case (cls_i)
      CLS_REG:    alu_op_o = table_op(funct3_i, alt, 1'b1);
      CLS_IMM:    alu_op_o = table_op(funct3_i, alt, 1'b0);
      CLS_BRANCH: alu_op_o = ALU_SUB;
      default:    alu_op_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter int ALT_BIT = 5
) (
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [F3_W-1:0]    funct3_i,
  input  logic [F7_W-1:0]    funct7_i,
  output logic               reg_write_o,
  output logic               alu_src_o,
  output logic               mem_read_o,
  output logic               mem_write_o,
  output logic               branch_o,
  output logic [ALUOP_W-1:0] alu_op_o,
  output logic [WBSEL_W-1:0] wb_sel_o
);

  instr_class_e cls;
  ctrl_bits_t   ctrl;
  alu_op_e      op;

  opcode_classifier u_cls (
    .opcode_i (opcode_i),
    .cls_o    (cls)
  );

  main_ctrl u_main (
    .cls_i  (cls),
    .ctrl_o (ctrl)
  );

  alu_op_decoder #(.ALT_BIT(ALT_BIT)) u_alu (
    .cls_i    (cls),
    .funct3_i (funct3_i),
    .funct7_i (funct7_i),
    .alu_op_o (op)
  );

  assign reg_write_o = ctrl.reg_write;
  assign alu_src_o   = ctrl.alu_src;
  assign mem_read_o  = ctrl.mem_read;
  assign mem_write_o = ctrl.mem_write;
  assign branch_o    = ctrl.branch;
  assign wb_sel_o    = ctrl.wb_sel;
  assign alu_op_o    = op;

  // cross-unit consistency between the enable decode and the ALU decode
  always_comb begin
    AST_MEM_EXCLUSIVE: assert (!(mem_read_o && mem_write_o)); // R11
    AST_BRANCH_NO_WB: assert (!(branch_o && reg_write_o)); // R11
    if (branch_o) begin
      AST_BRANCH_SUB: assert (alu_op_o == ALU_SUB); // R7
    end
    if (mem_read_o) begin
      AST_LOAD_MEM_WB: assert (wb_sel_o == WB_MEM && alu_op_o == ALU_ADD); // R5
    end
    if (mem_write_o) begin
      AST_STORE_NO_REG: assert (!reg_write_o && alu_op_o == ALU_ADD); // R6
    end
    if (!reg_write_o && !mem_read_o && !mem_write_o && !branch_o) begin
      AST_IDLE_QUIET: assert (alu_op_o == ALU_ADD && wb_sel_o == WB_ALU); // R10
    end
    if (reg_write_o && !alu_src_o) begin
      AST_REG_FORM_ALU_WB: assert (wb_sel_o == WB_ALU); // R1
    end
  end

endmodule

// File: tb/sim_ctrl_decoder.sv
module sim_ctrl_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic       rw, src, mr, mw, br;
  logic [3:0] op;
  logic [1:0] wb;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ctrl_decoder u0 (
    .opcode_i    (opcode),
    .funct3_i    (funct3),
    .funct7_i    (funct7),
    .reg_write_o (rw),
    .alu_src_o   (src),
    .mem_read_o  (mr),
    .mem_write_o (mw),
    .branch_o    (br),
    .alu_op_o    (op),
    .wb_sel_o    (wb)
  );

  // expected word layout: {rw, src, mr, mw, br, op[3:0], wb[1:0]}
  task automatic apply_check(input string req, input logic [6:0] o,
                             input logic [2:0] f3, input logic [6:0] f7,
                             input logic [10:0] exp);
    logic [10:0] act;
    @(negedge clk);
    opcode = o; funct3 = f3; funct7 = f7;
    #2;
    act = {rw, src, mr, mw, br, op, wb};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s opc=%b f3=%b f7=%b actual=%b expected=%b",
               req, o, f3, f7, act, exp);
    end
  endtask

  function automatic logic [10:0] w(input logic a, input logic b, input logic c,
                                    input logic d, input logic e,
                                    input logic [3:0] p, input logic [1:0] s);
    return {a, b, c, d, e, p, s};
  endfunction

  task automatic t_reset_state();
    // R10: all-zero opcode after reset is unrecognised
    apply_check("R10", 7'b0000000, 3'b000, 7'b0000000, w(0,0,0,0,0,4'd0,2'd0));
  endtask

  task automatic t_reg_plain();
    apply_check("R1", 7'b0110011, 3'b000, 7'b0000000, w(1,0,0,0,0,4'd0,2'd0));
    apply_check("R2", 7'b0110011, 3'b001, 7'b0000000, w(1,0,0,0,0,4'd7,2'd0));
    apply_check("R2", 7'b0110011, 3'b010, 7'b0000000, w(1,0,0,0,0,4'd5,2'd0));
    apply_check("R2", 7'b0110011, 3'b011, 7'b0000000, w(1,0,0,0,0,4'd6,2'd0));
    apply_check("R2", 7'b0110011, 3'b100, 7'b0000000, w(1,0,0,0,0,4'd4,2'd0));
    apply_check("R2", 7'b0110011, 3'b101, 7'b0000000, w(1,0,0,0,0,4'd8,2'd0));
    apply_check("R2", 7'b0110011, 3'b110, 7'b0000000, w(1,0,0,0,0,4'd3,2'd0));
    apply_check("R2", 7'b0110011, 3'b111, 7'b0000000, w(1,0,0,0,0,4'd2,2'd0));
  endtask

  task automatic t_reg_alt();
    apply_check("R3", 7'b0110011, 3'b000, 7'b0100000, w(1,0,0,0,0,4'd1,2'd0));
    apply_check("R3", 7'b0110011, 3'b101, 7'b0100000, w(1,0,0,0,0,4'd9,2'd0));
    apply_check("R3", 7'b0110011, 3'b111, 7'b0100000, w(1,0,0,0,0,4'd2,2'd0));
    apply_check("R3", 7'b0110011, 3'b100, 7'b0100000, w(1,0,0,0,0,4'd4,2'd0));
  endtask

  task automatic t_op_imm();
    apply_check("R4", 7'b0010011, 3'b000, 7'b0100000, w(1,1,0,0,0,4'd0,2'd0));
    apply_check("R4", 7'b0010011, 3'b101, 7'b0100000, w(1,1,0,0,0,4'd9,2'd0));
    apply_check("R4", 7'b0010011, 3'b101, 7'b0000000, w(1,1,0,0,0,4'd8,2'd0));
    apply_check("R4", 7'b0010011, 3'b110, 7'b1111111, w(1,1,0,0,0,4'd3,2'd0));
  endtask

  task automatic t_load_store();
    apply_check("R5", 7'b0000011, 3'b010, 7'b0100000, w(1,1,1,0,0,4'd0,2'd1));
    apply_check("R6", 7'b0100011, 3'b101, 7'b0100000, w(0,1,0,1,0,4'd0,2'd0));
  endtask

  task automatic t_branch();
    for (int f = 0; f < 8; f++) begin
      apply_check("R7", 7'b1100011, 3'(f), 7'b0000000, w(0,0,0,0,1,4'd1,2'd0));
    end
    apply_check("R7", 7'b1100011, 3'b101, 7'b0100000, w(0,0,0,0,1,4'd1,2'd0));
  endtask

  task automatic t_jumps();
    apply_check("R8", 7'b1101111, 3'b000, 7'b0100000, w(1,1,0,0,0,4'd0,2'd2));
    apply_check("R8", 7'b1100111, 3'b101, 7'b0100000, w(1,1,0,0,0,4'd0,2'd2));
  endtask

  task automatic t_upper();
    apply_check("R9", 7'b0110111, 3'b101, 7'b0100000, w(1,1,0,0,0,4'd0,2'd3));
    apply_check("R9", 7'b0010111, 3'b000, 7'b0100000, w(1,1,0,0,0,4'd0,2'd3));
  endtask

  task automatic t_unknown();
    apply_check("R10", 7'b0001111, 3'b000, 7'b0100000, w(0,0,0,0,0,4'd0,2'd0));
    apply_check("R10", 7'b1110011, 3'b101, 7'b0100000, w(0,0,0,0,0,4'd0,2'd0));
    apply_check("R10", 7'b0110001, 3'b000, 7'b0100000, w(0,0,0,0,0,4'd0,2'd0));
    apply_check("R10", 7'b1111111, 3'b111, 7'b1111111, w(0,0,0,0,0,4'd0,2'd0));
  endtask

  task automatic t_exclusion_sweep();
    // R11: sweep every opcode with alternate funct fields
    for (int o = 0; o < 128; o++) begin
      @(negedge clk);
      opcode = 7'(o); funct3 = 3'b101; funct7 = 7'b0100000;
      #2;
      checks++;
      if ((mr && mw) || (br && rw)) begin
        failures++;
        $display("FAIL R11 opc=%b actual mr=%b mw=%b br=%b rw=%b expected no overlap",
                 7'(o), mr, mw, br, rw);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opcode = '0; funct3 = '0; funct7 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_reg_plain();
    t_reg_alt();
    t_op_imm();
    t_load_store();
    t_branch();
    t_jumps();
    t_upper();
    t_unknown();
    t_exclusion_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule